// File: doc/BRIEF.md
# Bit-Oriented Message Detector

This block watches the serial receive data-link stream of a T1 extended-superframe link. It looks for 16-bit bit-oriented message codewords. Each codeword is a run of eight ones, a zero, six code bits and a closing zero. It qualifies a message once the same code has arrived a programmable number of times back to back. The data-link bits arrive at about 4 kb/s. Each bit is marked by a one-cycle strobe in the system clock domain, so the block does work only on strobed cycles.

Two state machines do the work. The alignment machine has two states. In `ST_HUNT` it tests every strobed bit for a complete codeword at any bit position. Finding one (transition *acquire*) moves it to `ST_LOCK`. In `ST_LOCK` it tests only the slot boundary 16 bits after the previous codeword. A good slot (transition *confirm*) stays in `ST_LOCK`. A bad slot (transition *slip*) returns to `ST_HUNT`. The qualifier machine has three states. `Q_IDLE` means no run is in progress. `Q_RUN` means a run is counting below the threshold. `Q_MET` means the threshold has been reached for the current run. A codeword with a new code (transition *restart*) starts a run at count 1. A repeat of the same code (transition *repeat*) adds one to the count. Reaching the threshold (transition *detect*) stores the code and sets the sticky flag. A slip (transition *drop*) returns to `Q_IDLE` with the count at 0.

Top module: `bom_detector`

## Requirements
- R1: After reset, `msg_code_o` is 0 and `msg_valid_o` is 0.
- R2: A codeword, in arrival order, is eight ones, a zero, the six code bits least significant bit first, and a zero. On detection, `msg_code_o` carries the six code bits with the first-arrived code bit at bit 0.
- R3: With an effective threshold T, `msg_valid_o` sets on the strobe edge of the last bit of the T-th consecutive identical codeword, and not earlier.
- R4: A codeword whose code differs from the previous one restarts the repeat count at 1.
- R5: Once aligned, a 16-bit slot that does not form a codeword resets the count to 0. Alignment is then searched again at every bit position.
- R6: `rep_thr_i` values 1 to 10 are used as given. A value of 0 acts as 1, and values 11 to 15 act as 10.
- R7: `msg_valid_o` stays set until `clr_i` is pulsed. A pulse clears it on the next edge unless a detection happens on that same edge, in which case the flag stays set.
- R8: A detection while `msg_valid_o` is already set overwrites `msg_code_o` with the new code.
- R9: A run detects at most once. Further repeats of the same code after a clear do not set the flag again until the run restarts.
- R10: Only cycles with `dl_en_i` high carry data. `msg_code_o` and `msg_valid_o` never become set or change through unstrobed cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dl_bit_i | input | 1 | Receive data-link bit |
| dl_en_i | input | 1 | One-cycle strobe marking a valid data-link bit |
| rep_thr_i | input | 4 | Consecutive-repeat threshold, 1 to 10 after clamping |
| clr_i | input | 1 | Clears the sticky detection flag |
| msg_code_o | output | 6 | Last detected message code |
| msg_valid_o | output | 1 | Sticky flag: a valid message was detected |

## Verification
The assertions check on every cycle that the flag rises only on a strobed edge and falls only after a clear. They also check that the stored code changes only together with a set flag, that nothing changes without a strobe, and that a lone clear takes effect on the next edge. Only the bench's scenarios can show that a detection needs exactly T identical codewords. The same holds for the threshold clamping, the restart on a new code, the count reset after a framing slip, the least-significant-first code order, the overwrite of a standing code, and the single detection per run.

// File: rtl/bom_pkg.sv
package bom_pkg;
    localparam int SYNC_LEN = 8;
    localparam int CODE_W   = 6;
    localparam int WORD_LEN = SYNC_LEN + CODE_W + 2;
    localparam int POS_W    = $clog2(WORD_LEN);
    localparam int THR_W    = 4;
    localparam int THR_MIN  = 1;
    localparam int THR_MAX  = 10;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [THR_W-1:0]  thr_t;

    typedef enum logic {
        ST_HUNT,
        ST_LOCK
    } align_st_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_RUN,
        Q_MET
    } qual_st_e;

    // Map an out-of-range programmed threshold onto the legal range.
    function automatic thr_t clamp_thr(input thr_t raw);
        if (raw < thr_t'(THR_MIN))
            return thr_t'(THR_MIN);
        else if (raw > thr_t'(THR_MAX))
            return thr_t'(THR_MAX);
        else
            return raw;
    endfunction
endpackage

// File: rtl/bom_shift.sv
module bom_shift
    import bom_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_i,
    input  logic                en_i,
    output logic [WORD_LEN-1:0] win_o
);
    // Oldest bit sits at index 0; the incoming bit enters at the top.
    logic [WORD_LEN-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (en_i)
            sr_q <= win_o;
    end

    // Window as it will look once the present bit is shifted in.
    always_comb begin
        win_o = {bit_i, sr_q[WORD_LEN-1:1]};
    end
endmodule

// File: rtl/bom_word_match.sv
module bom_word_match
    import bom_pkg::*;
(
    input  logic [WORD_LEN-1:0] win_i,
    output logic                match_o,
    output code_t               code_o
);
    logic sync_ok;
    logic sep_ok;
    logic tail_ok;

    always_comb begin
        sync_ok = &win_i[SYNC_LEN-1:0];
        sep_ok  = ~win_i[SYNC_LEN];
        tail_ok = ~win_i[WORD_LEN-1];
        match_o = sync_ok & sep_ok & tail_ok;
        // Least significant code bit arrived first and so has the lowest index.
        code_o  = win_i[SYNC_LEN+CODE_W:SYNC_LEN+1];
    end
endmodule

// File: rtl/bom_align_fsm.sv
module bom_align_fsm
    import bom_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic match_i,
    output logic good_o,
    output logic bad_o
);
    align_st_e        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        pos_d  = pos_q;
        good_o = 1'b0;
        bad_o  = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (en_i && match_i) begin
                    good_o = 1'b1;
                    st_d   = ST_LOCK;
                    pos_d  = '0;
                end
            end
            ST_LOCK: begin
                if (en_i) begin
                    if (pos_q == LAST_POS) begin
                        pos_d = '0;
                        if (match_i) begin
                            good_o = 1'b1;
                        end else begin
                            bad_o = 1'b1;
                            st_d  = ST_HUNT;
                        end
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end
endmodule

// File: rtl/bom_qualify.sv
module bom_qualify
    import bom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  good_i,
    input  logic  bad_i,
    input  code_t code_i,
    input  thr_t  thr_i,
    input  logic  clr_i,
    output code_t code_o,
    output logic  valid_o
);
    qual_st_e st_q, st_d;
    thr_t     cnt_q, cnt_d;
    code_t    last_q, last_d;
    code_t    code_q, code_d;
    logic     flag_q, flag_d;
    logic     detect;
    thr_t     thr_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= Q_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
            code_q <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            last_q <= last_d;
            code_q <= code_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        thr_eff = clamp_thr(thr_i);
        st_d    = st_q;
        cnt_d   = cnt_q;
        last_d  = last_q;
        detect  = 1'b0;
        if (bad_i) begin
            st_d  = Q_IDLE;
            cnt_d = '0;
        end else if (good_i) begin
            unique case (st_q)
                Q_IDLE: begin
                    cnt_d  = thr_t'(1);
                    last_d = code_i;
                    detect = (thr_eff == thr_t'(1));
                    st_d   = detect ? Q_MET : Q_RUN;
                end
                Q_RUN: begin
                    last_d = code_i;
                    if (code_i != last_q) begin
                        cnt_d  = thr_t'(1);
                        detect = (thr_eff == thr_t'(1));
                    end else begin
                        cnt_d  = cnt_q + 1'b1;
                        detect = ((cnt_q + 1'b1) >= thr_eff);
                    end
                    st_d = detect ? Q_MET : Q_RUN;
                end
                Q_MET: begin
                    if (code_i != last_q) begin
                        last_d = code_i;
                        cnt_d  = thr_t'(1);
                        detect = (thr_eff == thr_t'(1));
                        st_d   = detect ? Q_MET : Q_RUN;
                    end
                end
                default: st_d = Q_IDLE;
            endcase
        end
    end

    always_comb begin
        code_d = detect ? code_i : code_q;
        if (detect)
            flag_d = 1'b1;
        else if (clr_i)
            flag_d = 1'b0;
        else
            flag_d = flag_q;
        code_o  = code_q;
        valid_o = flag_q;
    end
endmodule

// File: rtl/bom_detector.sv
module bom_detector
    import bom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_bit_i,
    input  logic              dl_en_i,
    input  logic [THR_W-1:0]  rep_thr_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] msg_code_o,
    output logic              msg_valid_o
);
    logic [WORD_LEN-1:0] win;
    logic                match;
    code_t               cand_code;
    logic                good;
    logic                bad;

    bom_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (dl_bit_i),
        .en_i  (dl_en_i),
        .win_o (win)
    );

    bom_word_match u_match (
        .win_i   (win),
        .match_o (match),
        .code_o  (cand_code)
    );

    bom_align_fsm u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dl_en_i),
        .match_i (match),
        .good_o  (good),
        .bad_o   (bad)
    );

    bom_qualify u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .good_i  (good),
        .bad_i   (bad),
        .code_i  (cand_code),
        .thr_i   (rep_thr_i),
        .clr_i   (clr_i),
        .code_o  (msg_code_o),
        .valid_o (msg_valid_o)
    );
endmodule

// File: rtl/bom_detector_chk.sv
module bom_detector_chk
    import bom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dl_en_i,
    input logic              clr_i,
    input logic [CODE_W-1:0] msg_code_o,
    input logic              msg_valid_o
);
    // R10
    flag_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid_o) |-> $past(dl_en_i));

    // R7
    flag_fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_valid_o) |-> $past(clr_i));

    // R8
    code_change_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msg_code_o) |-> msg_valid_o);

    // R10
    code_hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_en_i |=> $stable(msg_code_o));

    // R7
    lone_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !dl_en_i) |=> !msg_valid_o);
endmodule

bind bom_detector bom_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dl_en_i     (dl_en_i),
    .clr_i       (clr_i),
    .msg_code_o  (msg_code_o),
    .msg_valid_o (msg_valid_o)
);

// File: tb/sim_bom_detector.sv
module sim_bom_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_bit_i = 1'b0;
    logic       dl_en_i = 1'b0;
    logic [3:0] rep_thr_i = 4'd1;
    logic       clr_i = 1'b0;
    logic [5:0] msg_code_o;
    logic       msg_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bom_detector u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dl_bit_i    (dl_bit_i),
        .dl_en_i     (dl_en_i),
        .rep_thr_i   (rep_thr_i),
        .clr_i       (clr_i),
        .msg_code_o  (msg_code_o),
        .msg_valid_o (msg_valid_o)
    );

    function automatic int eff_thr(input logic [3:0] t);
        if (t == 0) return 1;
        if (t > 10) return 10;
        return int'(t);
    endfunction

    function automatic logic exp_flag(input int reps, input logic [3:0] t);
        return reps >= eff_thr(t);
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: flag actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_code(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: code actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        dl_bit_i = b;
        dl_en_i  = 1'b1;
        @(negedge clk);
        dl_en_i  = 1'b0;
        dl_bit_i = $urandom_range(0, 1);
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic send_word(input logic [5:0] c);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(c[i]);
        send_bit(1'b0);
    endtask

    task automatic send_words(input logic [5:0] c, input int n);
        for (int i = 0; i < n; i++) send_word(c);
    endtask

    task automatic slip();
        for (int i = 0; i < 16; i++) send_bit(1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1BAD5EED));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_bit("R1", msg_valid_o, 1'b0);
        chk_code("R1", msg_code_o, 6'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1", msg_valid_o, 1'b0);
        chk_code("R1", msg_code_o, 6'h00);

        // R3 and R2: threshold 3, asymmetric code checks bit order
        rep_thr_i = 4'd3;
        send_words(6'h2A, 2);
        chk_bit("R3", msg_valid_o, 1'b0);
        send_word(6'h2A);
        chk_bit("R3", msg_valid_o, 1'b1);
        chk_code("R2", msg_code_o, 6'h2A);

        // R7 and R9: clear, then more repeats of the same run
        pulse_clr();
        chk_bit("R7", msg_valid_o, 1'b0);
        send_words(6'h2A, 3);
        chk_bit("R9", msg_valid_o, 1'b0);

        // R4: a different code restarts the count
        send_words(6'h03, 2);
        chk_bit("R4", msg_valid_o, 1'b0);
        send_word(6'h03);
        chk_bit("R4", msg_valid_o, 1'b1);
        chk_code("R4", msg_code_o, 6'h03);

        // R8: overwrite while flag set
        rep_thr_i = 4'd2;
        send_words(6'h30, 2);
        chk_bit("R8", msg_valid_o, 1'b1);
        chk_code("R8", msg_code_o, 6'h30);

        // R5: framing break resets count, realign at an odd offset
        pulse_clr();
        rep_thr_i = 4'd3;
        send_words(6'h19, 2);
        slip();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        send_words(6'h19, 2);
        chk_bit("R5", msg_valid_o, 1'b0);
        send_word(6'h19);
        chk_bit("R5", msg_valid_o, 1'b1);
        chk_code("R5", msg_code_o, 6'h19);

        // R6: threshold 0 acts as 1
        slip();
        pulse_clr();
        rep_thr_i = 4'd0;
        send_word(6'h01);
        chk_bit("R6", msg_valid_o, 1'b1);
        chk_code("R6", msg_code_o, 6'h01);

        // R6: threshold 15 acts as 10
        slip();
        pulse_clr();
        rep_thr_i = 4'd15;
        send_words(6'h20, 9);
        chk_bit("R6", msg_valid_o, 1'b0);
        send_word(6'h20);
        chk_bit("R6", msg_valid_o, 1'b1);
        chk_code("R6", msg_code_o, 6'h20);

        // R10: unstrobed codeword pattern is ignored
        slip();
        pulse_clr();
        rep_thr_i = 4'd1;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            dl_bit_i = (i % 16) < 8 ? 1'b1 : 1'b0;
        end
        chk_bit("R10", msg_valid_o, 1'b0);
        chk_code("R10", msg_code_o, 6'h20);

        // Random scenarios: R3 with random code, threshold and count
        for (int s = 0; s < 40; s++) begin
            logic [5:0] c;
            logic [3:0] t;
            int k;
            c = 6'($urandom_range(0, 63));
            t = 4'($urandom_range(0, 15));
            k = $urandom_range(0, 11);
            slip();
            pulse_clr();
            rep_thr_i = t;
            send_words(c, k);
            chk_bit("R3", msg_valid_o, exp_flag(k, t));
            if (exp_flag(k, t)) chk_code("R2", msg_code_o, c);
        end

        finish_run();
    end
endmodule